// File: doc/BRIEF.md
# Handshaked Binary32 Adder

The block adds two IEEE-754 single-precision values and returns the rounded sum. A producer offers both operands and a 5-bit tag by raising an input strobe. The block accepts them with a single-cycle acknowledge, works through a fixed state sequence, then presents the sum and the unchanged tag behind an output strobe. The output stays valid until the consumer acknowledges it. Only one operation is in flight at a time.

The datapath handles normal and subnormal values, signed zeros, infinities and NaNs, and rounds to nearest with ties to even. Exponents are aligned with guard, round and sticky bits, so the bits shifted out still take part in rounding. Magnitudes beyond the finite range become a signed infinity. Every NaN result is replaced by a single quiet NaN, 0x7FC00000.

Top module: `fpadd_hs`

## Requirements
- R1: After reset, out_stb, out_z and out_tag are 0, and in_ack is 0 while in_stb is low.
- R2: in_ack is high only when the block is idle and in_stb is high. It is high for exactly one cycle per accepted operation, and it stays low while an operation is in flight or a result is waiting to be taken.
- R3: Once out_stb rises, it stays high with out_z and out_tag unchanged until a cycle in which out_ack is high. It is low in the following cycle.
- R4: out_tag equals the in_tag captured with the operands of that operation.
- R5: An operand with exponent field 0xFF and a nonzero fraction is a NaN. Any NaN operand gives out_z = 0x7FC00000, and every NaN result is exactly that value.
- R6: +inf (0x7F800000) plus -inf (0xFF800000), in either order, gives 0x7FC00000.
- R7: An infinity plus any zero or finite value, or plus an infinity of the same sign, gives that infinity with its sign.
- R8: Finite operands of equal magnitude and opposite sign give +0 (0x00000000). Two zeros give a zero whose sign bit is the AND of the two operand signs.
- R9: Subnormal operands (exponent field 0) and subnormal results are exact before rounding. For example, 0x00000047 + 0x80000048 = 0x80000001.
- R10: A rounded magnitude at or beyond 2^128 gives a signed infinity. For example, 0xFE34F995 + 0xFF5D59AD = 0xFF800000.
- R11: Rounding is to nearest with ties to even, and bits lost during alignment count towards the decision. For example, 0x4E5693A4 + 0x42500000 = 0x4E5693A5.
- R12: An operand smaller than half a unit in the last place of the other leaves the other unchanged. For example, 0x42500000 + 0x51A7A358 = 0x51A7A358.
- R13: Ordinary normal sums and differences are correctly rounded. For example, 0x463B800A + 0xC2BA8A3D = 0x463A0AF6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| in_tag | input | 5 | Tag that travels with the operation |
| in_stb | input | 1 | Operands and tag are valid |
| in_ack | output | 1 | Operands are captured in this cycle |
| out_z | output | 32 | Rounded sum, binary32 |
| out_tag | output | 5 | Tag of the operation that produced out_z |
| out_stb | output | 1 | Result is valid |
| out_ack | input | 1 | Consumer takes the result |

## Verification
Three cases are hard to reach from the ports. The first is a result that needs the guard, round and sticky bits together: the sticky bit is only set when a far smaller operand is shifted almost, but not entirely, out of the mantissa. The second is a difference that leaves a subnormal result, where the normalising left shift must be limited by the exponent. The third is a sum that carries into the exponent at the top of the finite range.

The stimulus reaches these with hand-built operand pairs: exponent gaps of 23 to 25, subnormal minus subnormal, and near-maximum magnitudes. The consumer also holds each result for zero to two extra cycles while the producer already offers its next operation. This exercises the hold of the output and the refusal of new operands during that wait.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int EXT_W  = MAN_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int XW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);

  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [XW-1:0]     exp;
    logic [MAN_W-1:0]  man;
    logic              is_nan;
    logic              is_inf;
    logic              is_zero;
  } opnd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_SUM, ST_NORM, ST_PACK, ST_HOLD
  } fsm_t;

  // right shift keeping a sticky OR of every bit shifted out
  function automatic logic [EXT_W-1:0] shr_sticky(logic [EXT_W-1:0] v,
                                                  logic [XW-1:0] d);
    logic [EXT_W-1:0] lost;
    logic [EXT_W-1:0] kept;
    if (d >= XW'(EXT_W)) begin
      shr_sticky = {{(EXT_W-1){1'b0}}, |v};
    end else begin
      lost = v & ~({EXT_W{1'b1}} << d);
      kept = v >> d;
      shr_sticky = {kept[EXT_W-1:1], kept[0] | (|lost)};
    end
  endfunction

  // special operand combinations: {hit, word}
  function automatic logic [WORD_W:0] special_pick(opnd_t a, opnd_t b);
    logic [WORD_W-1:0] inf_a, inf_b;
    inf_a = {a.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    inf_b = {b.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    if (a.is_nan || b.is_nan)
      special_pick = {1'b1, QNAN};
    else if (a.is_inf && b.is_inf && (a.sign != b.sign))
      special_pick = {1'b1, QNAN};
    else if (a.is_inf)
      special_pick = {1'b1, inf_a};
    else if (b.is_inf)
      special_pick = {1'b1, inf_b};
    else if (a.is_zero && b.is_zero)
      special_pick = {1'b1, a.sign & b.sign, {(WORD_W-1){1'b0}}};
    else
      special_pick = {1'b0, {WORD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             info
);
  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;

  always_comb begin
    efield = word[WORD_W-2 -: EXP_W];
    ffield = word[FRAC_W-1:0];
    info.sign    = word[WORD_W-1];
    info.is_nan  = (&efield) && (|ffield);
    info.is_inf  = (&efield) && !(|ffield);
    info.is_zero = !(|efield) && !(|ffield);
    if (efield == '0) begin
      info.exp = XW'(1);
      info.man = {1'b0, ffield};
    end else begin
      info.exp = {2'b00, efield};
      info.man = {1'b1, ffield};
    end
  end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W = 27,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              sign,
  input  logic [XW-1:0]     exp,
  input  logic [EXT_W-1:0]  m,
  output logic [WORD_W-1:0] word
);
  logic             inc;
  logic [MAN_W:0]   mr;
  logic [MAN_W-1:0] man_f;
  logic [XW-1:0]    e_f;

  always_comb begin
    inc = m[2] & (m[1] | m[0] | m[3]);
    mr  = {1'b0, m[EXT_W-1:3]} + {{MAN_W{1'b0}}, inc};
    if (mr[MAN_W]) begin
      man_f = mr[MAN_W:1];
      e_f   = exp + XW'(1);
    end else begin
      man_f = mr[MAN_W-1:0];
      e_f   = exp;
    end
    if (e_f >= EXP_TOP)
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (man_f[MAN_W-1])
      word = {sign, e_f[EXP_W-1:0], man_f[FRAC_W-1:0]};
    else
      word = {sign, {EXP_W{1'b0}}, man_f[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpadd_hs.sv
module fpadd_hs
  import fpadd_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_stb,
  output logic              in_ack,
  output logic [WORD_W-1:0] out_z,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_stb,
  input  logic              out_ack
);
  fsm_t state;

  logic [WORD_W-1:0] op_w [2];
  opnd_t             cls  [2];
  logic [TAG_W-1:0]  tag_q;

  logic              spec_hit, spec_hit_q;
  logic [WORD_W-1:0] spec_word, spec_word_q;
  logic              swap;
  opnd_t             big, sml;
  logic [XW-1:0]     gap;

  logic [EXT_W-1:0]  big_m, sml_m;
  logic              r_sign, r_sub, r_zero;
  logic [XW-1:0]     r_exp;
  logic [SUM_W-1:0]  sum_q;
  logic [EXT_W-1:0]  norm_q;

  logic [LZ_W-1:0]   lz;
  logic [XW-1:0]     lz_x, exp_room, lshift;
  logic [WORD_W-1:0] rounded;

  // named events for the checker
  logic accept, deliver, busy;
  assign accept  = in_stb & in_ack;
  assign deliver = out_stb & out_ack;
  assign busy    = (state != ST_IDLE);
  assign in_ack  = (state == ST_IDLE) & in_stb;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpadd_classify u_cls (.word(op_w[g]), .info(cls[g]));
  end

  always_comb begin
    {spec_hit, spec_word} = special_pick(cls[0], cls[1]);
    swap = op_w[1][WORD_W-2:0] > op_w[0][WORD_W-2:0];
    big  = swap ? cls[1] : cls[0];
    sml  = swap ? cls[0] : cls[1];
    gap  = big.exp - sml.exp;
  end

  fpadd_lzc #(.W(EXT_W)) u_lzc (.v(sum_q[EXT_W-1:0]), .cnt(lz));

  always_comb begin
    lz_x     = {{(XW-LZ_W){1'b0}}, lz};
    exp_room = r_exp - XW'(1);
    lshift   = (lz_x < exp_room) ? lz_x : exp_room;
  end

  fpadd_round u_rnd (.sign(r_sign), .exp(r_exp), .m(norm_q), .word(rounded));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_w[0]     <= '0;
      op_w[1]     <= '0;
      tag_q       <= '0;
      spec_hit_q  <= 1'b0;
      spec_word_q <= '0;
      big_m       <= '0;
      sml_m       <= '0;
      r_sign      <= 1'b0;
      r_sub       <= 1'b0;
      r_zero      <= 1'b0;
      r_exp       <= '0;
      sum_q       <= '0;
      norm_q      <= '0;
      out_z       <= '0;
      out_tag     <= '0;
      out_stb     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_w[0] <= in_a;
            op_w[1] <= in_b;
            tag_q   <= in_tag;
            state   <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          spec_hit_q  <= spec_hit;
          spec_word_q <= spec_word;
          big_m       <= {big.man, 3'b000};
          sml_m       <= shr_sticky({sml.man, 3'b000}, gap);
          r_exp       <= big.exp;
          r_sign      <= big.sign;
          r_sub       <= big.sign ^ sml.sign;
          state       <= ST_SUM;
        end
        ST_SUM: begin
          sum_q <= r_sub ? ({1'b0, big_m} - {1'b0, sml_m})
                         : ({1'b0, big_m} + {1'b0, sml_m});
          state <= ST_NORM;
        end
        ST_NORM: begin
          r_zero <= (sum_q == '0);
          if (sum_q[SUM_W-1]) begin
            norm_q <= {sum_q[SUM_W-1:2], sum_q[1] | sum_q[0]};
            r_exp  <= r_exp + XW'(1);
          end else begin
            norm_q <= sum_q[EXT_W-1:0] << lshift;
            r_exp  <= r_exp - lshift;
          end
          state <= ST_PACK;
        end
        ST_PACK: begin
          if (spec_hit_q)  out_z <= spec_word_q;
          else if (r_zero) out_z <= '0;
          else             out_z <= rounded;
          out_tag <= tag_q;
          out_stb <= 1'b1;
          state   <= ST_HOLD;
        end
        ST_HOLD: begin
          if (deliver) begin
            out_stb <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpadd_hs_chk.sv
module fpadd_hs_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ack,
  input logic             in_stb,
  input logic [TAG_W-1:0] in_tag,
  input logic [31:0]      out_z,
  input logic [TAG_W-1:0] out_tag,
  input logic             out_stb,
  input logic             out_ack,
  input logic             busy
);
  logic [TAG_W-1:0] seen_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_tag <= '0;
    else if (in_stb && in_ack) seen_tag <= in_tag;
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);

  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || out_stb) |-> !in_ack);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && !out_ack) |=> (out_stb && $stable(out_z) && $stable(out_tag)));

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && out_ack) |=> !out_stb);

  assert_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> (out_tag == seen_tag));

  assert_qnan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && (&out_z[30:23]) && (|out_z[22:0])) |-> (out_z == 32'h7FC0_0000));
endmodule

bind fpadd_hs fpadd_hs_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ack(in_ack), .in_stb(in_stb), .in_tag(in_tag),
  .out_z(out_z), .out_tag(out_tag), .out_stb(out_stb), .out_ack(out_ack),
  .busy(busy)
);

// File: tb/sim_fpadd_hs.sv
`timescale 1ns/1ps
module sim_fpadd_hs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [4:0]  in_tag = '0;
  logic        in_stb = 1'b0;
  logic        in_ack;
  logic [31:0] out_z;
  logic [4:0]  out_tag;
  logic        out_stb;
  logic        out_ack = 1'b0;

  typedef struct {
    logic [31:0] z;
    logic [4:0]  tag;
    string       req;
  } item_t;

  item_t exp_q [$];
  int    n_cmp = 0, n_bad = 0, n_sent = 0, n_done = 0;
  bit    drv_done = 0;

  always #10 clk = ~clk;

  fpadd_hs u0 (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .in_stb(in_stb), .in_ack(in_ack), .out_z(out_z), .out_tag(out_tag),
    .out_stb(out_stb), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] want);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, want);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] z, input string req);
    bit   got = 0;
    bit   bad = 0;
    item_t it;
    @(negedge clk);
    in_a = a; in_b = b; in_tag = 5'(n_sent); in_stb = 1'b1;
    while (!got) begin
      #1;
      if (in_ack && out_stb) bad = 1;
      if (in_ack) got = 1;
      else @(negedge clk);
    end
    it.z = z; it.tag = 5'(n_sent); it.req = req;
    exp_q.push_back(it);
    n_sent++;
    check(!bad, "R2 no accept while result pending", 32'(bad), 32'd0);
    @(posedge clk);
    #1;
    check(in_ack == 1'b0, "R2 ack is one cycle", 32'(in_ack), 32'd0);
    @(negedge clk);
    in_stb = 1'b0;
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (out_stb) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected result", out_z, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(out_z == e.z, e.req, out_z, e.z);
          check(out_tag == e.tag, "R4 tag", 32'(out_tag), 32'(e.tag));
          for (int k = 0; k < n_done % 3; k++) begin
            @(negedge clk);
            check(out_stb && out_z == e.z, "R3 held until ack", out_z, e.z);
          end
          out_ack = 1'b1;
          @(negedge clk);
          out_ack = 1'b0;
          check(out_stb == 1'b0, "R3 drops after ack", 32'(out_stb), 32'd0);
        end
        n_done++;
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    check(1'b0, "watchdog expired", 32'(n_done), 32'(n_sent));
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_stb == 1'b0, "R1 out_stb", 32'(out_stb), 32'd0);
    check(out_z == 32'd0, "R1 out_z", out_z, 32'd0);
    check(out_tag == 5'd0, "R1 out_tag", 32'(out_tag), 32'd0);
    check(in_ack == 1'b0, "R1 in_ack", 32'(in_ack), 32'd0);

    drive(32'h3F800000, 32'h40000000, 32'h40400000, "R13 1+2");
    drive(32'h447A0000, 32'h4488B000, 32'h4502D800, "R13 add");
    drive(32'h463B800A, 32'hC2BA8A3D, 32'h463A0AF6, "R13 sub");
    drive(32'hC2BA8A3D, 32'h463B800A, 32'h463A0AF6, "R13 sub swapped");
    drive(32'h7ED01F25, 32'hFF559E2C, 32'hFEDB1D33, "R13 negative diff");
    drive(32'hFFFFFFFF, 32'hC63B800A, 32'h7FC00000, "R5 nan a");
    drive(32'h3F800000, 32'h7F800001, 32'h7FC00000, "R5 nan b");
    drive(32'hFF800000, 32'h7F800000, 32'h7FC00000, "R6 -inf+inf");
    drive(32'h7F800000, 32'hFF800000, 32'h7FC00000, "R6 +inf-inf");
    drive(32'h7F800000, 32'h00000000, 32'h7F800000, "R7 inf+0");
    drive(32'h00000000, 32'hFF800000, 32'hFF800000, "R7 0-inf");
    drive(32'hFF800000, 32'hFF800000, 32'hFF800000, "R7 -inf-inf");
    drive(32'h7F800000, 32'hC63B800A, 32'h7F800000, "R7 inf+finite");
    drive(32'h42540000, 32'hC2540000, 32'h00000000, "R8 cancel");
    drive(32'hC2540000, 32'h42540000, 32'h00000000, "R8 cancel swapped");
    drive(32'h80000000, 32'h80000000, 32'h80000000, "R8 -0 + -0");
    drive(32'h00000000, 32'h80000000, 32'h00000000, "R8 +0 + -0");
    drive(32'h00000047, 32'h80000048, 32'h80000001, "R9 sub-sub");
    drive(32'h006CE3EE, 32'h806CE3EC, 32'h00000002, "R9 small diff");
    drive(32'h00018643, 32'h00FA72A4, 32'h00FBF8E7, "R9 sub+normal");
    drive(32'h001A2239, 32'h00FA72A4, 32'h010A4A6E, "R9 carry out");
    drive(32'h82471F51, 32'h0243985F, 32'h801C3790, "R9 to subnormal");
    drive(32'hFE34F995, 32'hFF5D59AD, 32'hFF800000, "R10 neg overflow");
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R10 pos overflow");
    drive(32'h4E5693A4, 32'h42500000, 32'h4E5693A5, "R11 sticky up");
    drive(32'h7F7FFFEE, 32'h758A0CF8, 32'h7F7FFFFF, "R11 near top");
    drive(32'h3F7FFFFE, 32'h3F7FFFFE, 32'h3FFFFFFE, "R11 doubling");
    drive(32'h7F7FFFEE, 32'h756CA884, 32'h7F7FFFFD, "R11 round");
    drive(32'h42500000, 32'h51A7A358, 32'h51A7A358, "R12 tiny a");
    drive(32'h51A7A358, 32'h42500000, 32'h51A7A358, "R12 tiny b");
    drive(32'h36093399, 32'h7F6A12F1, 32'h7F6A12F1, "R12 huge gap");
    drive(32'h7F7FFFEE, 32'hFEFFFFEE, 32'h7EFFFFEE, "R13 halving");
    drive_done_wait();
  end

  task automatic drive_done_wait();
    drv_done = 1;
    while (n_done < n_sent) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard empty", 32'(exp_q.size()), 32'd0);
    finish_run();
  endtask
endmodule